// File: doc/BRIEF.md
# Addressed Serial Control Register Receiver

This block takes configuration words from a three-wire serial port and turns them into two parallel 16-bit registers. The three wires are a data line, a shift clock and a load strobe. A frame is 24 bits. The first 16 bits are the control word, sent most significant bit first. The last 8 bits are a device address. The strobe stays high while bits are shifted in. When the strobe is pulled low, the block checks the trailing address against its own fixed address. If the address matches, the control word is written to one of the two registers. Bit 15 of the word chooses which register receives it.

All serial wires are brought into the system clock domain through two synchronising flops. This makes the timing deterministic: a register write appears a fixed number of system cycles after the strobe falls.

A second path carries an audio sample stream through one register stage. When the mute bit of the level register is set, the sample data on this path is forced to zero. The valid flag passes through unchanged, so whatever produces the samples keeps running.

Top module: `ctlrx_top`

## Requirements
- R1: After reset both registers read zero, `smp_valid_o` is 0 and `smp_data_o` is zero, so mute is off.
- R2: Serial bits are taken most significant bit first. The first bit of a frame ends up in bit 15 of the written register.
- R3: A frame is the last 24 bits shifted in before the strobe falls. The first 16 of these bits are the control word and the final 8 bits are the address.
- R4: A frame is written only when its 8-bit address equals 0xE7. For any other address, neither register changes.
- R5: Bit 15 of the word picks the target: 0 writes `sys_reg_o` and 1 writes `lvl_reg_o`. The whole 16-bit word, bit 15 included, is stored.
- R6: When the strobe is driven low between clock edges, the write is visible after the third rising system clock edge. It is not visible after the second edge.
- R7: Rising shift-clock edges that occur while the strobe is low do not shift any bit.
- R8: If a frame has fewer or more than 24 shift edges, the last 24 bits received are decoded. For a short frame, these include bits left over from earlier frames.
- R9: `smp_valid_o` is `smp_valid_i` delayed by one cycle. `smp_data_o` is `smp_data_i` delayed by one cycle, except when bit 14 of `lvl_reg_o` is 1; then it is zero.
- R10: A sample registered on the same edge as a level-register write uses the old mute value. The next sample uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_stb_i | input | 1 | Load strobe, high while shifting, falls to load |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 24 | Input sample data |
| smp_valid_o | output | 1 | Output sample valid |
| smp_data_o | output | 24 | Output sample data, zero while muted |
| sys_reg_o | output | 16 | System configuration register |
| lvl_reg_o | output | 16 | Level register; bit 14 is the mute bit |

## Verification
The main collision is a level-register write and a sample transfer on the same system clock edge. At that edge the old mute value must still apply (R10). The bench drives a random valid/data stream on every cycle while frames arrive, so writes that toggle the mute bit land on both valid and idle cycles. A behavioural model updates its expected mute value only after computing the expected sample for that same edge. Each output is compared with the model on every clock.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;
  localparam int CTRL_W   = 16;
  localparam int ADDR_W   = 8;
  localparam int FRAME_W  = CTRL_W + ADDR_W;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 8'hE7;

  typedef struct packed {
    logic [CTRL_W-1:0] word;
    logic [ADDR_W-1:0] addr;
  } frame_t;
endpackage

// File: rtl/ctlrx_sync.sv
module ctlrx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/ctlrx_shifter.sv
module ctlrx_shifter
  import ctlrx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sclk_s,
  input  logic   sdat_s,
  input  logic   stb_s,
  output frame_t frame_o,
  output logic   load_o
);
  logic               sclk_d;
  logic               stb_d;
  logic [FRAME_W-1:0] shreg;
  logic               shift_en;

  assign shift_en = sclk_s & ~sclk_d & stb_s;
  assign load_o   = stb_d & ~stb_s;
  assign frame_o  = frame_t'(shreg);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      stb_d  <= 1'b1;
      shreg  <= '0;
    end else begin
      sclk_d <= sclk_s;
      stb_d  <= stb_s;
      if (shift_en) shreg <= {shreg[FRAME_W-2:0], sdat_s};
    end
  end

  // R7: nothing is shifted while the strobe is low
  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> $stable(shreg));
endmodule

// File: rtl/ctlrx_regs.sv
module ctlrx_regs
  import ctlrx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MY_ADDR = DEV_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  frame_t            frame_i,
  output logic [CTRL_W-1:0] sys_q,
  output logic [CTRL_W-1:0] lvl_q
);
  logic hit;
  assign hit = load_i && (frame_i.addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= '0;
      lvl_q <= '0;
    end else if (hit) begin
      if (frame_i.word[CTRL_W-1]) lvl_q <= frame_i.word;
      else                        sys_q <= frame_i.word;
    end
  end

  p_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && frame_i.addr != MY_ADDR) |=> ($stable(sys_q) && $stable(lvl_q)));
  p_only_on_load_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(sys_q) && $stable(lvl_q)));
  p_sys_sel_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sys_q) |-> !sys_q[CTRL_W-1]);
  p_lvl_sel_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> lvl_q[CTRL_W-1]);
endmodule

// File: rtl/ctlrx_mute.sv
module ctlrx_mute #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mute_i,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= mute_i ? '0 : in_data;
    end
  end

  p_mute_zero_r9: assert property (@(posedge clk) disable iff (rst)
    mute_i |=> out_data == '0);
  p_pass_r10: assert property (@(posedge clk) disable iff (rst)
    !mute_i |=> out_data == $past(in_data));
  p_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));
endmodule

// File: rtl/ctlrx_top.sv
module ctlrx_top
  import ctlrx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SYNC_N    = 2,
  parameter int MUTE_BIT  = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk_i,
  input  logic                ser_dat_i,
  input  logic                ser_stb_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                smp_valid_o,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic [CTRL_W-1:0]   sys_reg_o,
  output logic [CTRL_W-1:0]   lvl_reg_o
);
  logic [2:0] pins_s;
  frame_t     frame;
  logic       load;

  ctlrx_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst(rst),
    .d_i({ser_stb_i, ser_clk_i, ser_dat_i}),
    .q_o(pins_s)
  );

  ctlrx_shifter i_shift (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[1]), .sdat_s(pins_s[0]), .stb_s(pins_s[2]),
    .frame_o(frame), .load_o(load)
  );

  ctlrx_regs #(.MY_ADDR(DEV_ADDR)) i_regs (
    .clk(clk), .rst(rst),
    .load_i(load), .frame_i(frame),
    .sys_q(sys_reg_o), .lvl_q(lvl_reg_o)
  );

  ctlrx_mute #(.SAMPLE_W(SAMPLE_W)) i_mute (
    .clk(clk), .rst(rst),
    .mute_i(lvl_reg_o[MUTE_BIT]),
    .in_valid(smp_valid_i), .in_data(smp_data_i),
    .out_valid(smp_valid_o), .out_data(smp_data_o)
  );
endmodule

// File: tb/test_ctlrx_top.sv
module test_ctlrx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdat = 1'b0, stb = 1'b1;
  logic        vin = 1'b0;
  logic [23:0] din = '0;
  logic        vout;
  logic [23:0] dout;
  logic [15:0] sys_o, lvl_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [23:0] bitsr = '0;
  logic [2:0]  ph;
  logic [15:0] e_sys, e_lvl;
  logic        e_v;
  logic [23:0] e_d;
  logic [15:0] w_sys = '0, w_lvl = '0;

  always #10 clk = ~clk;

  ctlrx_top i_ctlrx_top (
    .clk(clk), .rst(rst),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_stb_i(stb),
    .smp_valid_i(vin), .smp_data_i(din),
    .smp_valid_o(vout), .smp_data_o(dout),
    .sys_reg_o(sys_o), .lvl_reg_o(lvl_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      ph <= 3'b111; e_sys <= '0; e_lvl <= '0; e_v <= 1'b0; e_d <= '0;
    end else begin
      ph <= {ph[1:0], stb};
      if (ph[2] && !ph[1] && bitsr[7:0] == 8'hE7) begin
        if (bitsr[23]) e_lvl <= bitsr[23:8];
        else           e_sys <= bitsr[23:8];
      end
      e_v <= vin;
      e_d <= e_lvl[14] ? 24'd0 : din;
    end
  end

  always @(negedge clk) begin
    vin <= ($urandom % 4) != 0;
    din <= 24'($urandom);
    if (!rst && !done) begin
      chk(sys_o == e_sys, "R2 R3 R4 R5 R7 R8 sys", {16'd0, sys_o}, {16'd0, e_sys});
      chk(lvl_o == e_lvl, "R4 R5 R6 lvl", {16'd0, lvl_o}, {16'd0, e_lvl});
      chk(vout == e_v, "R9 valid", {31'd0, vout}, {31'd0, e_v});
      chk(dout == e_d, "R9 R10 data", {8'd0, dout}, {8'd0, e_d});
    end
  end

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdat = v[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      if (stb) bitsr = {bitsr[22:0], v[i]};
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic latch(input logic [15:0] xs, input logic [15:0] xl);
    logic [15:0] ps, pl;
    ps = sys_o; pl = lvl_o;
    @(negedge clk) stb = 1'b0;
    repeat (2) @(negedge clk);
    chk(sys_o == ps && lvl_o == pl, "R6 early", {sys_o, lvl_o}, {ps, pl});
    @(negedge clk);
    chk(sys_o == xs && lvl_o == xl, "R6 on time", {sys_o, lvl_o}, {xs, xl});
    repeat (3) @(negedge clk);
    stb = 1'b1;
    repeat (6) @(negedge clk);
    w_sys = xs; w_lvl = xl;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sys_o == 0, "R1 sys", {16'd0, sys_o}, 0);
    chk(lvl_o == 0, "R1 lvl", {16'd0, lvl_o}, 0);
    chk(vout == e_v, "R1 valid", {31'd0, vout}, {31'd0, e_v});
    chk(lvl_o[14] == 1'b0, "R1 mute off", {31'd0, lvl_o[14]}, 0);

    // R2 R3 R5: system register write
    send_bits({40'd0, 16'h1235, 8'hE7}, 24); latch(16'h1235, 16'h0000);
    // R5: level register write
    send_bits({40'd0, 16'h8A5A, 8'hE7}, 24); latch(16'h1235, 16'h8A5A);
    // R4: wrong addresses rejected
    send_bits({40'd0, 16'h0777, 8'hE6}, 24); latch(16'h1235, 16'h8A5A);
    send_bits({40'd0, 16'h8777, 8'h67}, 24); latch(16'h1235, 16'h8A5A);
    // R7: edges under a low strobe must not shift
    send_bits({40'd0, 16'h2468, 8'h00}, 24); latch(16'h1235, 16'h8A5A);
    @(negedge clk) stb = 1'b0;
    repeat (4) @(negedge clk);
    send_bits({56'd0, 8'hE7}, 8);
    stb = 1'b1;
    repeat (6) @(negedge clk);
    latch(16'h1235, 16'h8A5A);
    chk(sys_o == 16'h1235, "R7 ignored edges", {16'd0, sys_o}, 32'h1235);
    // R8: short and long frames
    send_bits({40'd0, 16'h0111, 8'hE7}, 24); latch(16'h0111, 16'h8A5A);
    send_bits({56'd0, 8'hE7}, 8); latch(16'h11E7, 16'h8A5A);
    send_bits({32'd0, 32'hFF8004E7}, 32); latch(16'h11E7, 16'h8004);
    // R9 R10: mute on, then off
    send_bits({40'd0, 16'hC000, 8'hE7}, 24); latch(16'h11E7, 16'hC000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(dout == 0, "R9 muted", {8'd0, dout}, 0);
    end
    send_bits({40'd0, 16'h8005, 8'hE7}, 24); latch(16'h11E7, 16'h8005);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(dout == e_d, "R10 unmuted", {8'd0, dout}, {8'd0, e_d});
    end
    // random frames, judged by the model
    for (int k = 0; k < 12; k++) begin
      logic [15:0] w;
      logic [7:0]  a;
      w = 16'($urandom);
      a = (k % 3 == 2) ? 8'($urandom) : 8'hE7;
      send_bits({40'd0, w, a}, 24);
      @(negedge clk) stb = 1'b0;
      repeat (8) @(negedge clk);
      stb = 1'b1;
      repeat (6) @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule